// File: doc/BRIEF.md
# Host Bit-Address Mapper

This block converts between the index of an emulated memory unit and a 64-bit host bit address. A host bit address is a 58-bit word index above a 6-bit bit offset. Emulated units of a fixed length are packed a whole number to each 64-bit host word, and the leftover low-order bits of each word go unused. This lets non-power-of-two word sizes, such as 36-bit words, sit in 64-bit host memory.

The block offers four operations, chosen by `op`:

- Decode turns a unit index into a bit address.
- Encode turns a bit address back into a unit index.
- Increment and decrement step a bit address within a word whose usable bits end at a programmable limit.

A request is presented with a one-cycle `start`. Decode runs a serial divider and takes 65 further clock edges. The other three operations finish on the accepting edge. Every completion is marked by a one-cycle `done`. `prm_err` reports whether the packing parameters of the completed request were impossible.

Top module: `hamap_top`

## Requirements
- R1: While `rst_n` is low, `result` is zero and `done` and `prm_err` are low.
- R2: Decode (op=0): with u = units per word (`prm_a`) and l = unit length (`prm_b`), `result` = {low 58 bits of src/u, low 6 bits of (src mod u)·l}.
- R3: A decode accepted on clock edge E sets `done` high for one cycle after edge E+65, and only then updates `result`.
- R4: A value of zero on `prm_a` or `prm_b` stands for 64. This holds for units per word, unit length and step size.
- R5: Encode (op=1): `result` = u·src[63:6] + src[5:0]/l, modulo 2^64.
- R6: Increment (op=2): with step s = `prm_a` and limit L = `prm_b`, the offset src[5:0]+s is formed at 7 bits. If it is at least L, the offset becomes 0 and the word index src[63:6] rises by one. Otherwise the offset becomes the sum and the word index is kept.
- R7: Decrement (op=3): if src[5:0]−s is negative, the offset becomes the low 6 bits of L−s and the word index falls by one. Otherwise the offset becomes the difference and the word index is kept.
- R8: For decode or encode with u·l > 64, `done` pulses on the accepting edge, `prm_err` goes high and `result` keeps its value. Any error-free completion clears `prm_err`.
- R9: Encode, increment, decrement and erroneous requests raise `done` for one cycle right after the accepting edge, and back-to-back requests are each completed.
- R10: A `start` sampled on edges E+1 to E+65 of an accepted decode is ignored. It causes no `done` and no change of `result`. A `start` sampled on edge E+66, while the decode's `done` is high, is accepted.
- R11: The word index wraps modulo 2^58 on increment and decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| op | input | 2 | 0 decode, 1 encode, 2 increment, 3 decrement |
| src | input | 64 | Unit index or host bit address |
| prm_a | input | 6 | Units per word, or step size (0 = 64) |
| prm_b | input | 6 | Unit length (0 = 64), or offset limit |
| result | output | 64 | Last completed result |
| done | output | 1 | Completion strobe |
| prm_err | output | 1 | Completed request had u·l > 64 |

## Verification
A decode can complete in the same cycle as the arrival of a new single-cycle request. The bench times a new request against a running decode:

- One `start` is placed in the cycle where the divider has finished but has not yet written its result. That request must vanish.
- The next `start` is placed in the cycle where the decode's `done` is visible. That request must produce its own `done` on the following cycle, with its own value.

A cycle-by-cycle model predicts `done`, `result` and `prm_err` for every clock, so a dropped, doubled or misplaced completion is caught.

// File: rtl/hamap_pkg.sv
package hamap_pkg;
  localparam int ADDR_W = 64;
  localparam int OFS_W  = 6;

  typedef enum logic [1:0] {
    OP_DECODE = 2'd0,
    OP_ENCODE = 2'd1,
    OP_INC    = 2'd2,
    OP_DEC    = 2'd3
  } map_op_e;

  // a zero field stands for the full word width
  function automatic logic [OFS_W:0] widen(input logic [OFS_W-1:0] v);
    return (v == '0) ? (OFS_W+1)'(1 << OFS_W) : {1'b0, v};
  endfunction
endpackage

// File: rtl/hamap_div.sv
module hamap_div #(
  parameter int DW = 64,
  parameter int VW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic [DW-1:0] quo,
  output logic [VW-1:0] rem,
  output logic          busy,
  output logic          fin
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] quo_q, quo_d;
  logic [VW-1:0] rem_q, rem_d, dvs_q, dvs_d, shifted;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, fin_q, fin_d, ge;

  always_comb begin
    shifted = {rem_q[VW-2:0], quo_q[DW-1]};
    ge      = shifted >= dvs_q;
    quo_d = quo_q;
    rem_d = rem_q;
    dvs_d = dvs_q;
    cnt_d = cnt_q;
    run_d = run_q;
    fin_d = 1'b0;
    if (load) begin
      quo_d = dividend;
      rem_d = '0;
      dvs_d = divisor;
      cnt_d = CW'(DW);
      run_d = 1'b1;
    end else if (run_q) begin
      quo_d = {quo_q[DW-2:0], ge};
      rem_d = ge ? shifted - dvs_q : shifted;
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      quo_q <= quo_d;
      rem_q <= rem_d;
      dvs_q <= dvs_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
      fin_q <= fin_d;
    end
  end

  assign quo  = quo_q;
  assign rem  = rem_q;
  assign busy = run_q | fin_q;
  assign fin  = fin_q;
endmodule

// File: rtl/hamap_encode.sv
module hamap_encode #(
  parameter int AW = 64,
  parameter int OW = 6
) (
  input  logic [AW-1:0] src,
  input  logic [OW:0]   upw,
  input  logic [OW:0]   ulen,
  output logic [AW-1:0] idx
);
  localparam int IW = AW - OW;
  logic [IW+OW:0] scaled;
  logic [OW:0]    part;

  always_comb begin
    scaled = src[AW-1:OW] * upw;
    part   = {1'b0, src[OW-1:0]} / ulen;
    idx    = scaled[AW-1:0] + AW'(part);
  end
endmodule

// File: rtl/hamap_step.sv
module hamap_step #(
  parameter int AW = 64,
  parameter int OW = 6
) (
  input  logic [AW-1:0] src,
  input  logic [OW:0]   stp,
  input  logic [OW-1:0] lim,
  input  logic          down,
  output logic [AW-1:0] addr
);
  localparam int IW = AW - OW;
  logic [IW-1:0] word;
  logic [OW:0]   sum;
  logic [OW+1:0] diff;
  logic [OW-1:0] refill;

  always_comb begin
    word   = src[AW-1:OW];
    sum    = {1'b0, src[OW-1:0]} + stp;
    diff   = {2'b0, src[OW-1:0]} - {1'b0, stp};
    refill = lim - stp[OW-1:0];
    if (!down) begin
      if (sum >= {1'b0, lim}) addr = {word + 1'b1, {OW{1'b0}}};
      else                    addr = {word, sum[OW-1:0]};
    end else begin
      if (diff[OW+1])         addr = {word - 1'b1, refill};
      else                    addr = {word, diff[OW-1:0]};
    end
  end
endmodule

// File: rtl/hamap_top.sv
module hamap_top
  import hamap_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [AW-1:0] src,
  input  logic [OW-1:0] prm_a,
  input  logic [OW-1:0] prm_b,
  output logic [AW-1:0] result,
  output logic          done,
  output logic          prm_err
);
  localparam int IW   = AW - OW;
  localparam int PW   = OW + 1;
  localparam int FULL = 1 << OW;

  logic [PW-1:0]   wa, wb, len_q, len_d, rem;
  logic [2*PW-1:0] span, frac;
  logic [AW-1:0]   quo, enc_val, stp_val, res_q, res_d;
  logic            div_busy, div_fin, accept, bad, div_load;
  logic            done_q, done_d, err_q, err_d;

  assign wa       = widen(prm_a);
  assign wb       = widen(prm_b);
  assign span     = wa * wb;
  assign accept   = start & ~div_busy;
  assign bad      = (op == OP_DECODE || op == OP_ENCODE) && (span > (2*PW)'(FULL));
  assign div_load = accept && (op == OP_DECODE) && !bad;
  assign frac     = rem * len_q;

  hamap_div #(.DW(AW), .VW(PW)) u_div (
    .clk(clk), .rst_n(rst_n), .load(div_load), .dividend(src), .divisor(wa),
    .quo(quo), .rem(rem), .busy(div_busy), .fin(div_fin)
  );

  hamap_encode #(.AW(AW), .OW(OW)) u_enc (
    .src(src), .upw(wa), .ulen(wb), .idx(enc_val)
  );

  hamap_step #(.AW(AW), .OW(OW)) u_step (
    .src(src), .stp(wa), .lim(prm_b), .down(op == OP_DEC), .addr(stp_val)
  );

  always_comb begin
    res_d  = res_q;
    done_d = 1'b0;
    err_d  = err_q;
    len_d  = div_load ? wb : len_q;
    if (div_fin) begin
      res_d  = {quo[IW-1:0], frac[OW-1:0]};
      done_d = 1'b1;
      err_d  = 1'b0;
    end else if (accept) begin
      if (bad) begin
        done_d = 1'b1;
        err_d  = 1'b1;
      end else if (op != OP_DECODE) begin
        res_d  = (op == OP_ENCODE) ? enc_val : stp_val;
        done_d = 1'b1;
        err_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      len_q  <= '0;
    end else begin
      res_q  <= res_d;
      done_q <= done_d;
      err_q  <= err_d;
      len_q  <= len_d;
    end
  end

  assign result  = res_q;
  assign done    = done_q;
  assign prm_err = err_q;
endmodule

// File: rtl/hamap_chk.sv
module hamap_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    op,
  input logic [AW-1:0] result,
  input logic          done,
  input logic          prm_err,
  input logic          div_busy,
  input logic          div_fin
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && prm_err) |-> $stable(result));

  assert_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prm_err) |-> done);

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !div_busy && op != 2'd0) |=> done);

  assert_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_fin |=> done);

  assert_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && div_busy && !div_fin) |=> !done);
endmodule

bind hamap_top hamap_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .result(result),
  .done(done), .prm_err(prm_err), .div_busy(div_busy), .div_fin(div_fin)
);

// File: tb/tb_hamap_top.sv
module tb_hamap_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [63:0] src = '0;
  logic [5:0]  pa = '0, pb = '0;
  logic [63:0] result;
  logic        done, prm_err;

  always #10 clk = ~clk;

  hamap_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src(src),
    .prm_a(pa), .prm_b(pb), .result(result), .done(done), .prm_err(prm_err)
  );

  int errs = 0, checks = 0, cyc = 0, due = -1, busy_until = -1;
  logic [63:0] m_res = '0, n_res = '0;
  logic        m_err = 1'b0, n_err = 1'b0;
  string       due_tag = "R1";

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h (edge %0d)", rq, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // reference model, compared after every rising edge
  always @(posedge clk) begin
    cyc = cyc + 1;
    #5;
    if (cyc > 20000) begin
      errs++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      summary();
    end
    if (rst_n) begin
      if (cyc == due) begin
        m_res = n_res;
        m_err = n_err;
      end
      chk(done === (cyc == due), due_tag, "done", 64'(done), 64'(cyc == due));
      chk(result === m_res, due_tag, "result", result, m_res);
      chk(prm_err === m_err, due_tag, "prm_err", 64'(prm_err), 64'(m_err));
    end
  end

  function automatic longint unsigned w64(input logic [5:0] v);
    return (v == 0) ? 64 : longint'(v);
  endfunction

  // call at a falling edge; start is sampled on the next rising edge
  task automatic issue(input logic [1:0] o, input logic [63:0] s,
                       input logic [5:0] a, input logic [5:0] b, input string rq);
    int e;
    longint unsigned u, l, lim, off, word;
    longint d;
    bit er;
    op = o; src = s; pa = a; pb = b; start = 1'b1;
    e = cyc + 1;
    if (e > busy_until) begin
      u = w64(a); l = w64(b); lim = longint'(b);
      off = s & 64'd63; word = s >> 6;
      er = (o < 2) && (u * l > 64);
      n_err = er;
      n_res = m_res;
      due = e;
      busy_until = e;
      due_tag = rq;
      if (!er) begin
        case (o)
          2'd0: begin
            n_res = ((s / u) << 6) | (((s % u) * l) & 64'd63);
            due = e + 65;
            busy_until = e + 65;
          end
          2'd1: n_res = u * word + off / l;
          2'd2: n_res = (off + u >= lim) ? ((word + 1) << 6) : ((word << 6) | (off + u));
          default: begin
            d = longint'(off) - longint'(u);
            if (d < 0) n_res = ((word - 1) << 6) | ((lim - u) & 64'd63);
            else       n_res = (word << 6) | longint'(d);
          end
        endcase
      end
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic settle();
    while (cyc <= busy_until) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk(result === 64'd0, "R1", "reset result", result, 64'd0);
    chk(done === 1'b0, "R1", "reset done", 64'(done), 64'd0);
    chk(prm_err === 1'b0, "R1", "reset prm_err", 64'(prm_err), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    issue(2'd0, 64'd100, 6'd3, 6'd21, "R3"); settle();
    chk(result === 64'h855, "R2", "decode 3x21", result, 64'h855);
    issue(2'd0, 64'd1000, 6'd1, 6'd36, "R2"); settle();
    issue(2'd0, 64'h12345, 6'd0, 6'd1, "R4"); settle();
    issue(2'd0, 64'd77, 6'd1, 6'd0, "R4"); settle();

    issue(2'd1, 64'h855, 6'd3, 6'd21, "R5"); settle();
    chk(result === 64'd100, "R5", "encode 3x21", result, 64'd100);
    issue(2'd1, 64'hABC7, 6'd0, 6'd1, "R4"); settle();

    issue(2'd2, (64'd5 << 6) | 64'd10, 6'd20, 6'd60, "R6");
    issue(2'd2, (64'd5 << 6) | 64'd16, 6'd20, 6'd36, "R6");
    issue(2'd2, 64'd3, 6'd0, 6'd63, "R4");
    issue(2'd2, 64'hFFFF_FFFF_FFFF_FFC0 | 64'd35, 6'd1, 6'd36, "R11");
    issue(2'd3, (64'd5 << 6) | 64'd40, 6'd4, 6'd36, "R7");
    issue(2'd3, 64'd5 << 6, 6'd36, 6'd36, "R7");
    issue(2'd3, 64'd0, 6'd1, 6'd36, "R11");
    issue(2'd3, 64'd7, 6'd0, 6'd36, "R4");
    settle();

    issue(2'd0, 64'd123, 6'd8, 6'd9, "R8"); settle();
    issue(2'd1, 64'd5, 6'd0, 6'd2, "R8");
    issue(2'd2, 64'd1, 6'd2, 6'd36, "R8"); settle();

    // start sampled during a running decode and in its finish cycle (R10),
    // then in the cycle its done is visible (R9)
    issue(2'd0, 64'hDEAD_BEEF_0123, 6'd5, 6'd12, "R3");
    issue(2'd1, 64'd999, 6'd1, 6'd1, "R10");
    repeat (63) @(negedge clk);
    issue(2'd2, 64'd0, 6'd1, 6'd36, "R10");
    issue(2'd1, 64'h855, 6'd3, 6'd21, "R9");
    issue(2'd3, 64'd200, 6'd9, 6'd36, "R9");
    settle();

    repeat (3) @(negedge clk);
    summary();
  end
endmodule